// File: doc/BRIEF.md
# Write-Once Presence-Tagged Structure Memory

This block is a small structure store in which every word is written once and may then be read any number of times. Each word carries a presence flag that marks it FULL or EMPTY. A read of a FULL word is answered on the next cycle with the stored value and the requester's tag. A read of an EMPTY word gets no answer at that point. It is parked on a deferred list kept for that address. When the word is later written, every read parked on it is answered with the new value. The requester neither polls nor sends the read again.

Commands enter on a valid/ready port. The response port is also valid/ready and is backed by a single output register. Parked reads share one pool of linked entries. Each address owns a FIFO-ordered chain through that pool, so a single write replays its chain one response per cycle. A store to a word that is already FULL is refused and flagged. A clear command returns a word to EMPTY. Clearing a word that still has parked reads is flagged as well.

Top module: `istruct_mem`

## Requirements
- R1: After reset every word is EMPTY and no reads are parked. `cmd_ready_o` is 1 and `rsp_valid_o` is 0. Command encoding on `cmd_op_i`: 2'b00 read, 2'b01 write, 2'b10 clear, 2'b11 no operation.
- R2: A read accepted on a FULL word raises `rsp_valid_o` at the clock edge that accepts it. The response carries the stored value and the command's tag. A word can be read like this any number of times.
- R3: A read accepted on an EMPTY word produces no response. It is parked against that address.
- R4: A write accepted on an EMPTY word stores the value and marks the word FULL. Every read parked on that address is then answered with the stored value, one response per cycle on consecutive cycles, in arrival order. Reads parked on other addresses stay parked.
- R5: A write to a FULL word is rejected. `err_store_o` pulses for one cycle and the stored value is unchanged.
- R6: The pool holds 16 parked reads. While all 16 are in use, `cmd_ready_o` is 0 for a read of an EMPTY word. A read of a FULL word is still accepted.
- R7: From the edge that accepts a releasing write until the last parked read has been handed to the response register, `cmd_ready_o` is 0.
- R8: A clear returns a word to EMPTY. A later read of that word is parked, and a later write is accepted without `err_store_o`.
- R9: Clearing a word that has parked reads pulses `err_clear_o`. Those reads stay parked and are answered by the next write to the word.
- R10: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response tag and data hold stable and `cmd_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_op_i | input | 2 | Operation: read, write, clear, no-op |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_data_i | input | DATA_W | Write data |
| cmd_tag_i | input | TAG_W | Requester tag for reads |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_tag_o | output | TAG_W | Tag of the answered read |
| rsp_data_o | output | DATA_W | Value of the word read |
| err_store_o | output | 1 | One-cycle pulse: write to a FULL word rejected |
| err_clear_o | output | 1 | One-cycle pulse: clear of a word with parked reads |

## Verification
A corrupted presence flag shows up on the cycle after the next read of that word. Either a response appears that should have been parked, or an expected response never arrives. A broken chain link or head pointer shows up during release as a missing, repeated or reordered tag within the next few cycles. A wrong pool-occupancy state shows up at the ports when `cmd_ready_o` drops too early or too late on the sixteenth or seventeenth parked read.

// File: rtl/istruct_pkg.sv
package istruct_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NOP   = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE,
    ST_RELEASE
  } st_e;
endpackage

// File: rtl/istruct_words.sv
module istruct_words #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [WORDS-1:0]  full_q;
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= '0;
    else if (set_i) full_q[addr_i] <= 1'b1;
    else if (clr_i) full_q[addr_i] <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (set_i) mem_q[addr_i] <= data_i;
  end

  assign full_o = full_q[addr_i];
  assign data_o = mem_q[addr_i];
endmodule

// File: rtl/istruct_pool.sv
module istruct_pool #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 5,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             link_i,
  input  logic [IDX_W-1:0] link_prev_i,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic             full_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [IDX_W-1:0] rd_next_o
);
  logic [DEPTH-1:0] used_q;
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [IDX_W-1:0] next_q [DEPTH];

  // lowest free slot
  always_comb begin
    alloc_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!used_q[i]) alloc_idx_o = IDX_W'(i);
    end
  end

  assign full_o = &used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else begin
      if (free_i)  used_q[free_idx_i]  <= 1'b0;
      if (alloc_i) used_q[alloc_idx_o] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) tag_q[alloc_idx_o]  <= tag_i;
    if (link_i)  next_q[link_prev_i] <= alloc_idx_o;
  end

  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_next_o = next_q[rd_idx_i];
endmodule

// File: rtl/istruct_mem.sv
module istruct_mem
  import istruct_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 5,
  parameter int POOL_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [TAG_W-1:0]  cmd_tag_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              err_store_o,
  output logic              err_clear_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int IDX_W = $clog2(POOL_DEPTH);

  st_e               state_q;
  logic [ADDR_W-1:0] rel_addr_q;
  logic [IDX_W-1:0]  rel_idx_q;
  logic [WORDS-1:0]  pend_q;
  logic [IDX_W-1:0]  head_q [WORDS];
  logic [IDX_W-1:0]  tail_q [WORDS];

  logic              rsp_valid_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              err_store_q, err_clear_q;

  op_e               op;
  logic              acc, rsp_free, defer_req, rel_fire, rel_last;
  logic              word_set, word_clr, word_full;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;
  logic              pool_alloc, pool_link, pool_full;
  logic [IDX_W-1:0]  pool_idx, pool_next;
  logic [TAG_W-1:0]  pool_tag;

  assign op        = op_e'(cmd_op_i);
  assign rsp_free  = !rsp_valid_q || rsp_ready_i;
  assign word_addr = (state_q == ST_RELEASE) ? rel_addr_q : cmd_addr_i;
  assign defer_req = (op == OP_READ) && !word_full;
  assign cmd_ready_o = (state_q == ST_IDLE) && rsp_free && !(defer_req && pool_full);
  assign acc       = cmd_valid_i && cmd_ready_o;
  assign word_set  = acc && (op == OP_WRITE) && !word_full;
  assign word_clr  = acc && (op == OP_CLEAR);
  assign pool_alloc = acc && defer_req;
  assign pool_link  = pool_alloc && pend_q[cmd_addr_i];
  assign rel_fire  = (state_q == ST_RELEASE) && rsp_free;
  assign rel_last  = rel_idx_q == tail_q[rel_addr_q];

  istruct_words #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_words (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (word_set),
    .clr_i  (word_clr),
    .addr_i (word_addr),
    .data_i (cmd_data_i),
    .full_o (word_full),
    .data_o (word_data)
  );

  istruct_pool #(.DEPTH(POOL_DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (pool_alloc),
    .tag_i       (cmd_tag_i),
    .link_i      (pool_link),
    .link_prev_i (tail_q[cmd_addr_i]),
    .free_i      (rel_fire),
    .free_idx_i  (rel_idx_q),
    .rd_idx_i    (rel_idx_q),
    .alloc_idx_o (pool_idx),
    .full_o      (pool_full),
    .rd_tag_o    (pool_tag),
    .rd_next_o   (pool_next)
  );

  // per-address chains and release sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rel_addr_q <= '0;
      rel_idx_q  <= '0;
      pend_q     <= '0;
      for (int a = 0; a < WORDS; a++) begin
        head_q[a] <= '0;
        tail_q[a] <= '0;
      end
    end else if (state_q == ST_RELEASE) begin
      if (rel_fire) begin
        if (rel_last) begin
          pend_q[rel_addr_q] <= 1'b0;
          state_q            <= ST_IDLE;
        end else begin
          rel_idx_q <= pool_next;
        end
      end
    end else if (acc) begin
      if (pool_alloc) begin
        tail_q[cmd_addr_i] <= pool_idx;
        if (!pend_q[cmd_addr_i]) begin
          head_q[cmd_addr_i] <= pool_idx;
          pend_q[cmd_addr_i] <= 1'b1;
        end
      end
      if (word_set && pend_q[cmd_addr_i]) begin
        state_q    <= ST_RELEASE;
        rel_addr_q <= cmd_addr_i;
        rel_idx_q  <= head_q[cmd_addr_i];
      end
    end
  end

  // response register and error pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_tag_q   <= '0;
      rsp_data_q  <= '0;
      err_store_q <= 1'b0;
      err_clear_q <= 1'b0;
    end else begin
      err_store_q <= acc && (op == OP_WRITE) && word_full;
      err_clear_q <= word_clr && pend_q[cmd_addr_i];
      if (rel_fire) begin
        rsp_valid_q <= 1'b1;
        rsp_tag_q   <= pool_tag;
        rsp_data_q  <= word_data;
      end else if (acc && (op == OP_READ) && word_full) begin
        rsp_valid_q <= 1'b1;
        rsp_tag_q   <= cmd_tag_i;
        rsp_data_q  <= word_data;
      end else if (rsp_ready_i) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_tag_o   = rsp_tag_q;
  assign rsp_data_o  = rsp_data_q;
  assign err_store_o = err_store_q;
  assign err_clear_o = err_clear_q;
endmodule

// File: rtl/istruct_mem_chk.sv
module istruct_mem_chk
  import istruct_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [1:0]        cmd_op_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [TAG_W-1:0]  rsp_tag_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              err_store_o,
  input logic              err_clear_o
);
  logic acc_wr, acc_clr;
  assign acc_wr  = cmd_valid_i && cmd_ready_o && (cmd_op_i == OP_WRITE);
  assign acc_clr = cmd_valid_i && cmd_ready_o && (cmd_op_i == OP_CLEAR);

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_data_o)); // R10
  AST_STALL_BLOCKS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !cmd_ready_o); // R10
  AST_STORE_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_store_o |-> $past(acc_wr)); // R5
  AST_CLEAR_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clear_o |-> $past(acc_clr)); // R9
  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_store_o |=> !err_store_o || $past(acc_wr)); // R5
endmodule

bind istruct_mem istruct_mem_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_tag_o   (rsp_tag_o),
  .rsp_data_o  (rsp_data_o),
  .err_store_o (err_store_o),
  .err_clear_o (err_clear_o)
);

// File: tb/istruct_mem_bench.sv
module istruct_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic              cmd_ready_o;
  logic [1:0]        cmd_op_i = 2'b11;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [DATA_W-1:0] cmd_data_i = '0;
  logic [TAG_W-1:0]  cmd_tag_i = '0;
  logic              rsp_valid_o;
  logic              rsp_ready_i = 1'b1;
  logic [TAG_W-1:0]  rsp_tag_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic              err_store_o;
  logic              err_clear_o;

  istruct_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .POOL_DEPTH(16)) u_istruct_mem (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_addr_i, .cmd_data_i,
    .cmd_tag_i, .rsp_valid_o, .rsp_ready_i, .rsp_tag_o, .rsp_data_o, .err_store_o, .err_clear_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, n_rsp = 0, n_est = 0, n_ecl = 0;
  bit done = 0;
  logic [TAG_W-1:0]  log_tag  [256];
  logic [DATA_W-1:0] log_data [256];
  int                log_cyc  [256];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_valid_o && rsp_ready_i && n_rsp < 256) begin
        log_tag[n_rsp]  = rsp_tag_o;
        log_data[n_rsp] = rsp_data_o;
        log_cyc[n_rsp]  = cyc;
        n_rsp++;
      end
      if (err_store_o) n_est++;
      if (err_clear_o) n_ecl++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // called and returns at posedge + 1
  task automatic issue(logic [1:0] op, int addr, int data, int tag);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_addr_i  = ADDR_W'(addr);
    cmd_data_i  = DATA_W'(data);
    cmd_tag_i   = TAG_W'(tag);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    cmd_valid_i = 1'b0;
    cmd_op_i    = 2'b11;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_rsp(int idx, int tag, int data, string req);
    chk(idx < n_rsp, req, n_rsp, idx + 1);
    if (idx < n_rsp) begin
      chk(log_tag[idx] == TAG_W'(tag), req, int'(log_tag[idx]), tag);
      chk(log_data[idx] == DATA_W'(data), req, int'(log_data[idx]), data);
    end
  endtask

  task automatic t_reset();
    int b;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1", cmd_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1", rsp_valid_o, 0);
    @(posedge clk_i); #1;
    b = n_rsp;
    issue(2'b00, 0, 0, 1);
    idle(3);
    chk(n_rsp == b, "R1", n_rsp - b, 0);
    issue(2'b01, 0, 16'h0101, 0); // releases tag 1
    idle(3);
    expect_rsp(b, 1, 16'h0101, "R1");
  endtask

  task automatic t_defer_then_store();
    int b = n_rsp;
    issue(2'b00, 2, 0, 3);
    idle(4);
    chk(n_rsp == b, "R3", n_rsp - b, 0);
    issue(2'b01, 2, 16'hBEEF, 0);
    idle(3);
    chk(n_rsp == b + 1, "R4", n_rsp - b, 1);
    expect_rsp(b, 3, 16'hBEEF, "R4");
  endtask

  task automatic t_order();
    int b = n_rsp;
    issue(2'b00, 4, 0, 5);
    issue(2'b00, 4, 0, 6);
    issue(2'b00, 4, 0, 7);
    issue(2'b01, 4, 16'h1234, 0);
    chk(cmd_ready_o == 1'b0, "R7", cmd_ready_o, 0);
    idle(5);
    chk(n_rsp == b + 3, "R4", n_rsp - b, 3);
    expect_rsp(b, 5, 16'h1234, "R4");
    expect_rsp(b + 1, 6, 16'h1234, "R4");
    expect_rsp(b + 2, 7, 16'h1234, "R4");
    chk(log_cyc[b + 1] == log_cyc[b] + 1, "R4", log_cyc[b + 1] - log_cyc[b], 1);
    chk(log_cyc[b + 2] == log_cyc[b] + 2, "R4", log_cyc[b + 2] - log_cyc[b], 2);
  endtask

  task automatic t_full_read();
    int b = n_rsp;
    issue(2'b00, 4, 0, 9);
    chk(rsp_valid_o == 1'b1, "R2", rsp_valid_o, 1);
    chk(rsp_tag_o == TAG_W'(9), "R2", rsp_tag_o, 9);
    chk(rsp_data_o == 16'h1234, "R2", rsp_data_o, 16'h1234);
    issue(2'b00, 4, 0, 10);
    idle(2);
    chk(n_rsp == b + 2, "R2", n_rsp - b, 2);
    expect_rsp(b + 1, 10, 16'h1234, "R2");
  endtask

  task automatic t_double_store();
    int e = n_est;
    int b = n_rsp;
    issue(2'b01, 4, 16'h5555, 0);
    idle(2);
    chk(n_est == e + 1, "R5", n_est - e, 1);
    issue(2'b00, 4, 0, 11);
    idle(2);
    expect_rsp(b, 11, 16'h1234, "R5");
  endtask

  task automatic t_interleave();
    int b = n_rsp;
    issue(2'b00, 6, 0, 1);
    issue(2'b00, 7, 0, 2);
    issue(2'b00, 6, 0, 3);
    issue(2'b01, 7, 16'h7777, 0);
    idle(4);
    chk(n_rsp == b + 1, "R4", n_rsp - b, 1);
    expect_rsp(b, 2, 16'h7777, "R4");
    issue(2'b01, 6, 16'h6666, 0);
    idle(4);
    chk(n_rsp == b + 3, "R4", n_rsp - b, 3);
    expect_rsp(b + 1, 1, 16'h6666, "R4");
    expect_rsp(b + 2, 3, 16'h6666, "R4");
  endtask

  task automatic t_pool_full();
    int b = n_rsp;
    for (int i = 0; i < 16; i++) issue(2'b00, 9, 0, i);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 2'b00;
    cmd_addr_i  = 4'd9;
    cmd_tag_i   = 5'd16;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b0, "R6", cmd_ready_o, 0);
    #1 cmd_addr_i = 4'd4;
    #1 chk(cmd_ready_o == 1'b1, "R6", cmd_ready_o, 1);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 2'b11;
    idle(1);
    chk(n_rsp == b, "R6", n_rsp - b, 0);
    issue(2'b00, 4, 0, 17);
    idle(2);
    expect_rsp(b, 17, 16'h1234, "R6");
    issue(2'b01, 9, 16'hAAAA, 0);
    idle(20);
    chk(n_rsp == b + 17, "R6", n_rsp - b, 17);
    for (int i = 0; i < 16; i++) expect_rsp(b + 1 + i, i, 16'hAAAA, "R6");
  endtask

  task automatic t_clear();
    int e = n_ecl;
    int s = n_est;
    int b = n_rsp;
    issue(2'b10, 2, 0, 0);
    idle(2);
    chk(n_ecl == e, "R8", n_ecl - e, 0);
    issue(2'b00, 2, 0, 4);
    idle(3);
    chk(n_rsp == b, "R8", n_rsp - b, 0);
    issue(2'b01, 2, 16'h2222, 0);
    idle(3);
    chk(n_est == s, "R8", n_est - s, 0);
    expect_rsp(b, 4, 16'h2222, "R8");
  endtask

  task automatic t_clear_pending();
    int e = n_ecl;
    int b = n_rsp;
    issue(2'b00, 11, 0, 8);
    issue(2'b10, 11, 0, 0);
    idle(2);
    chk(n_ecl == e + 1, "R9", n_ecl - e, 1);
    chk(n_rsp == b, "R9", n_rsp - b, 0);
    issue(2'b01, 11, 16'hBBBB, 0);
    idle(3);
    expect_rsp(b, 8, 16'hBBBB, "R9");
  endtask

  task automatic t_backpressure();
    int b = n_rsp;
    issue(2'b00, 12, 0, 20);
    issue(2'b00, 12, 0, 21);
    rsp_ready_i = 1'b0;
    issue(2'b01, 12, 16'hCCCC, 0);
    idle(5);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b1, "R10", rsp_valid_o, 1);
    chk(rsp_tag_o == TAG_W'(20), "R10", rsp_tag_o, 20);
    chk(cmd_ready_o == 1'b0, "R10", cmd_ready_o, 0);
    chk(n_rsp == b, "R10", n_rsp - b, 0);
    @(posedge clk_i); #1;
    rsp_ready_i = 1'b1;
    idle(4);
    chk(n_rsp == b + 2, "R10", n_rsp - b, 2);
    expect_rsp(b, 20, 16'hCCCC, "R10");
    expect_rsp(b + 1, 21, 16'hCCCC, "R10");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_defer_then_store();
    t_order();
    t_full_read();
    t_double_store();
    t_interleave();
    t_pool_full();
    t_clear();
    t_clear_pending();
    t_backpressure();
    done = 1;
    summary();
  end
endmodule